// File: doc/BRIEF.md
# Clock Loss-of-Signal Monitor

This block supervises a set of input clocks and one reference clock, all sampled by a faster system clock. Each input first passes through a synchronizer and a rising-edge detector. A period meter then counts system-clock cycles between rising edges and compares every measured period against a window around a programmed nominal count. A period that is too short is treated as a phase irregularity. A period that is too long, or an edge that never arrives, is treated as a missing edge. Either one is an error event.

A per-channel qualifier turns these events into a loss status. It declares loss only after a programmed number of back-to-back error events, so isolated glitches can be tolerated. It withdraws loss after a programmed run of good periods. Each channel reports a live bit and a sticky bit. The sticky bit holds the history of loss until software writes a one to clear it.

The reference clock has its own monitor built from the same parts. By default, a loss on the reference pulls the downstream output-enable low. A keep-running control overrides that policy.

Top module: `clk_los_monitor`

## Requirements
- R1: A period between two rising edges, counted in system cycles, is good when it lies inside the inclusive window [nom_period - tol, nom_period + tol], and is an error event when it is shorter or longer.
- R2: If no rising edge arrives for nom_period + tol + 1 cycles, one error event is recorded and measurement restarts. The first edge after such a timeout, after enable or after reset, only re-arms the meter and is not judged.
- R3: Channel i declares loss when its count of consecutive error events reaches its fail threshold, the 4-bit field fail_thresh[4i+3:4i]; a threshold of 0 acts as 1. Fewer consecutive events than the threshold leave the status clear.
- R4: A channel in loss returns to no-loss once good_thresh consecutive good periods have been seen (0 acts as 1).
- R5: live_los[i] shows the current loss state of input i only; the channels are independent.
- R6: sticky_los[i] is set one cycle after live_los[i] is high. It stays set until a cycle in which sticky_clr[i] is 1 while live_los[i] is 0.
- R7: A clear that coincides with a cycle in which the sticky bit is being set by loss leaves the sticky bit set.
- R8: A channel with ch_en[i] at 0 reports live_los[i] = 0 from the next cycle on, whatever its input does, and restarts from a clean state when enabled again.
- R9: The reference monitor applies R1 to R4 with ref_nom_period, the shared tol, ref_fail_thresh and good_thresh. While ref_los is 1, out_enable is 0 unless keep_outputs is 1; otherwise out_enable is 1.
- R10: After reset, live_los, sticky_los and ref_los are all 0 and out_enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and counting |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_in | input | NUM_CH | Monitored input clocks (asynchronous) |
| ch_en | input | NUM_CH | Per-channel monitor enable |
| nom_period | input | CNT_W | Nominal input period in system cycles |
| tol | input | CNT_W | Allowed deviation from the nominal period, in cycles |
| fail_thresh | input | NUM_CH*SENS_W | Per-channel count of consecutive errors that declares loss |
| good_thresh | input | SENS_W | Count of consecutive good periods that withdraws loss |
| sticky_clr | input | NUM_CH | Write-one-to-clear strobe for the sticky bits |
| live_los | output | NUM_CH | Current loss state per channel |
| sticky_los | output | NUM_CH | Latched loss history per channel |
| ref_clk_in | input | 1 | Reference clock being monitored |
| ref_en | input | 1 | Reference monitor enable |
| ref_nom_period | input | CNT_W | Nominal reference period in system cycles |
| ref_fail_thresh | input | SENS_W | Consecutive errors that declare reference loss |
| keep_outputs | input | 1 | Keeps out_enable high during reference loss |
| ref_los | output | 1 | Current reference loss state |
| out_enable | output | 1 | Downstream output enable |

## Verification
A wrong period counter or window comparison shows up as live_los on a channel whose clock sits exactly on a window edge, such as nominal ± tol or one cycle outside it, within a few input periods. A qualifier run counter that does not reset, or an off-by-one threshold, appears at the ports as loss on a burst of missing edges that should have been tolerated, or as no loss on a burst that reaches the threshold. Sticky logic that is faulty is exposed within one cycle by the clear-during-loss case and by the check that the sticky bit survives the end of the loss.

// File: rtl/los_mon_pkg.sv
package los_mon_pkg;

   // Verdict produced by a period meter for one system cycle
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_GOOD = 2'd1,
      EV_BAD  = 2'd2
   } period_ev_e;

endpackage

// File: rtl/los_edge_sync.sv
// Brings an asynchronous clock into the system domain and flags its rising edges.
module los_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/los_period_meter.sv
// Counts system cycles between rising edges and judges each period.
module los_period_meter
   import los_mon_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rise,
   input  logic [CNT_W-1:0] nom,
   input  logic [CNT_W-1:0] tol,
   output period_ev_e       ev
);

   localparam int PW = CNT_W + 1;

   logic [PW-1:0] lo_lim;
   logic [PW-1:0] hi_lim;
   logic [PW-1:0] cnt_q;
   logic          armed_q;
   logic          in_window;
   logic          timed_out;

   assign hi_lim    = {1'b0, nom} + {1'b0, tol};
   assign lo_lim    = (nom > tol) ? {1'b0, nom - tol} : '0;
   assign in_window = (cnt_q >= lo_lim) && (cnt_q <= hi_lim);
   assign timed_out = cnt_q > hi_lim;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         ev      <= EV_NONE;
      end else begin
         ev <= EV_NONE;
         if (rise) begin
            cnt_q   <= {{(PW-1){1'b0}}, 1'b1};
            armed_q <= 1'b1;
            if (armed_q) begin
               ev <= in_window ? EV_GOOD : EV_BAD;
            end
         end else if (timed_out) begin
            // missing edge: one error, restart and wait for a fresh edge
            ev      <= EV_BAD;
            cnt_q   <= {{(PW-1){1'b0}}, 1'b1};
            armed_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + {{(PW-1){1'b0}}, 1'b1};
         end
      end
   end

endmodule

// File: rtl/los_qualifier.sv
// Turns period verdicts into a loss flag with fail and recovery run lengths.
module los_qualifier
   import los_mon_pkg::*;
#(
   parameter int SENS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  period_ev_e        ev,
   input  logic [SENS_W-1:0] fail_thr,
   input  logic [SENS_W-1:0] good_thr,
   output logic              los
);

   localparam logic [SENS_W-1:0] ONE_S  = {{(SENS_W-1){1'b0}}, 1'b1};
   localparam logic [SENS_W:0]   ONE_X  = {{SENS_W{1'b0}}, 1'b1};
   localparam logic [SENS_W-1:0] MAX_S  = '1;

   logic [SENS_W-1:0] bad_run_q;
   logic [SENS_W-1:0] good_run_q;
   logic [SENS_W-1:0] fail_eff;
   logic [SENS_W-1:0] good_eff;
   logic [SENS_W:0]   bad_next;
   logic [SENS_W:0]   good_next;

   assign fail_eff  = (fail_thr == '0) ? ONE_S : fail_thr;
   assign good_eff  = (good_thr == '0) ? ONE_S : good_thr;
   assign bad_next  = {1'b0, bad_run_q} + ONE_X;
   assign good_next = {1'b0, good_run_q} + ONE_X;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         bad_run_q  <= '0;
         good_run_q <= '0;
         los        <= 1'b0;
      end else begin
         case (ev)
            EV_BAD: begin
               good_run_q <= '0;
               if (bad_run_q != MAX_S) bad_run_q <= bad_next[SENS_W-1:0];
               if (bad_next >= {1'b0, fail_eff}) los <= 1'b1;
            end
            EV_GOOD: begin
               bad_run_q <= '0;
               if (good_run_q != MAX_S) good_run_q <= good_next[SENS_W-1:0];
               if (good_next >= {1'b0, good_eff}) los <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/clk_los_monitor.sv
module clk_los_monitor
   import los_mon_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 12,
   parameter int SENS_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        clk_in,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [CNT_W-1:0]         nom_period,
   input  logic [CNT_W-1:0]         tol,
   input  logic [NUM_CH*SENS_W-1:0] fail_thresh,
   input  logic [SENS_W-1:0]        good_thresh,
   input  logic [NUM_CH-1:0]        sticky_clr,
   output logic [NUM_CH-1:0]        live_los,
   output logic [NUM_CH-1:0]        sticky_los,
   input  logic                     ref_clk_in,
   input  logic                     ref_en,
   input  logic [CNT_W-1:0]         ref_nom_period,
   input  logic [SENS_W-1:0]        ref_fail_thresh,
   input  logic                     keep_outputs,
   output logic                     ref_los,
   output logic                     out_enable
);

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_num_ch
      $error("clk_los_monitor: NUM_CH out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_los_monitor: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 4 || SENS_W < 1) begin : g_bad_width
      $error("clk_los_monitor: counter widths too small");
   end

   // input clock channels
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic       rise;
      period_ev_e ev;

      los_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (ch_en[g]),
         .async_in (clk_in[g]),
         .rise     (rise)
      );

      los_period_meter #(.CNT_W(CNT_W)) u_meter (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ch_en[g]),
         .rise  (rise),
         .nom   (nom_period),
         .tol   (tol),
         .ev    (ev)
      );

      los_qualifier #(.SENS_W(SENS_W)) u_qual (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (ch_en[g]),
         .ev       (ev),
         .fail_thr (fail_thresh[g*SENS_W +: SENS_W]),
         .good_thr (good_thresh),
         .los      (live_los[g])
      );
   end

   // sticky history: set by live loss, cleared only by a write of one outside loss
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sticky_los <= '0;
      end else begin
         sticky_los <= live_los | (sticky_los & ~sticky_clr);
      end
   end

   // reference clock channel
   logic       ref_rise;
   period_ev_e ref_ev;

   los_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ref_en),
      .async_in (ref_clk_in),
      .rise     (ref_rise)
   );

   los_period_meter #(.CNT_W(CNT_W)) u_ref_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ref_en),
      .rise  (ref_rise),
      .nom   (ref_nom_period),
      .tol   (tol),
      .ev    (ref_ev)
   );

   los_qualifier #(.SENS_W(SENS_W)) u_ref_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ref_en),
      .ev       (ref_ev),
      .fail_thr (ref_fail_thresh),
      .good_thr (good_thresh),
      .los      (ref_los)
   );

   assign out_enable = keep_outputs | ~ref_los;

endmodule

// File: rtl/los_mon_chk.sv
module los_mon_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] live_los,
   input logic [NUM_CH-1:0] sticky_los,
   input logic [NUM_CH-1:0] sticky_clr,
   input logic              ref_en,
   input logic              ref_los
);

   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_los & ~ch_en & ~$past(ch_en)) == '0));

   // R8
   rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_los & ~$past(live_los) & ~$past(ch_en)) == '0));

   // R6
   sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sticky_los & $past(live_los)) == $past(live_los)));

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~sticky_los & $past(sticky_los) & ~$past(sticky_clr)) == '0));

   // R9
   ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_en && !$past(ref_en)) |-> !ref_los);

endmodule

bind clk_los_monitor los_mon_chk #(.NUM_CH(NUM_CH)) u_los_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_en      (ch_en),
   .live_los   (live_los),
   .sticky_los (sticky_los),
   .sticky_clr (sticky_clr),
   .ref_en     (ref_en),
   .ref_los    (ref_los)
);

// File: tb/clk_los_monitor_test.sv
module clk_los_monitor_test;

   localparam int NCH = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   ch_en = '1;
   logic [11:0]      nom_period = 12'd20;
   logic [11:0]      tol = 12'd2;
   logic [15:0]      fail_thresh = 16'h2222;
   logic [3:0]       good_thresh = 4'd3;
   logic [NCH-1:0]   sticky_clr = '0;
   logic [NCH-1:0]   live_los;
   logic [NCH-1:0]   sticky_los;
   logic             ref_en = 1'b1;
   logic [11:0]      ref_nom_period = 12'd16;
   logic [3:0]       ref_fail_thresh = 4'd2;
   logic             keep_outputs = 1'b0;
   logic             ref_los;
   logic             out_enable;

   // stimulus clock generators: index 4 is the reference
   int   per_p [5] = '{20, 20, 20, 20, 16};
   int   skip_n[5] = '{0, 0, 0, 0, 0};
   bit   stop_c[5] = '{0, 0, 0, 0, 0};
   int   ph    [5] = '{0, 0, 0, 0, 0};
   bit   skipping[5] = '{0, 0, 0, 0, 0};
   logic [4:0] src = '0;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      for (int k = 0; k < 5; k++) begin
         ph[k] = ph[k] + 1;
         if (ph[k] >= per_p[k]) begin
            ph[k] = 0;
            if (skip_n[k] > 0) begin
               skipping[k] = 1'b1;
               skip_n[k]   = skip_n[k] - 1;
            end else begin
               skipping[k] = 1'b0;
            end
         end
         src[k] = !stop_c[k] && !skipping[k] && (ph[k] < per_p[k] / 2);
      end
   end

   clk_los_monitor uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .clk_in          (src[3:0]),
      .ch_en           (ch_en),
      .nom_period      (nom_period),
      .tol             (tol),
      .fail_thresh     (fail_thresh),
      .good_thresh     (good_thresh),
      .sticky_clr      (sticky_clr),
      .live_los        (live_los),
      .sticky_los      (sticky_los),
      .ref_clk_in      (src[4]),
      .ref_en          (ref_en),
      .ref_nom_period  (ref_nom_period),
      .ref_fail_thresh (ref_fail_thresh),
      .keep_outputs    (keep_outputs),
      .ref_los         (ref_los),
      .out_enable      (out_enable)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_clr(input logic [NCH-1:0] m);
      sticky_clr = m;
      step(1);
      sticky_clr = '0;
   endtask

   // watch channel 0 for any loss during a window
   task automatic watch0(input int n, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         step(1);
         if (live_los[0]) seen = 1'b1;
      end
   endtask

   typedef struct packed {
      logic [7:0] period;
      logic [3:0] thr;
      logic       en;
      logic       exp_live;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{8'd20, 4'd2, 1'b1, 1'b0},   // R1 nominal
      '{8'd26, 4'd2, 1'b1, 1'b1},   // R2 too long, edges overdue
      '{8'd14, 4'd2, 1'b1, 1'b1},   // R1 too short
      '{8'd20, 4'd2, 1'b1, 1'b0},   // R4 recovery
      '{8'd18, 4'd2, 1'b1, 1'b0},   // R1 low edge of window
      '{8'd22, 4'd2, 1'b1, 1'b0},   // R1 high edge of window
      '{8'd17, 4'd2, 1'b1, 1'b1},   // R1 one below window
      '{8'd23, 4'd2, 1'b1, 1'b1},   // R1 one above window
      '{8'd40, 4'd2, 1'b0, 1'b0},   // R8 disabled with bad clock
      '{8'd21, 4'd0, 1'b1, 1'b0}    // R3 zero threshold, good clock
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      bit seen;
      step(5);
      rst_n = 1'b1;
      step(1);
      // R10 reset state
      check("R10 live", 32'(live_los), 32'h0);
      check("R10 sticky", 32'(sticky_los), 32'h0);
      check("R10 ref_los", 32'(ref_los), 32'h0);
      check("R10 out_enable", 32'(out_enable), 32'h1);

      step(200);
      foreach (VECS[i]) begin
         per_p[0] = int'(VECS[i].period);
         fail_thresh[3:0] = VECS[i].thr;
         ch_en[0] = VECS[i].en;
         step(40 * int'(VECS[i].period) + 200);
         check($sformatf("R1/R2/R4/R8 vector %0d live", i),
               32'(live_los[0]), 32'(VECS[i].exp_live));
      end
      ch_en[0] = 1'b1;
      per_p[0] = 20;
      fail_thresh[3:0] = 4'd2;
      step(400);
      check("R5 all clear", 32'(live_los), 32'h0);

      // R6 clear outside loss
      pulse_clr('1);
      step(2);
      check("R6 cleared", 32'(sticky_los), 32'h0);

      // R3 single missing edge tolerated with threshold 2
      skip_n[0] = 1;
      watch0(150, seen);
      check("R3 one miss tolerated", 32'(seen), 32'h0);
      check("R3 sticky untouched", 32'(sticky_los[0]), 32'h0);

      // R3 two consecutive misses reach threshold 2
      step(100);
      skip_n[0] = 2;
      watch0(150, seen);
      check("R3 two misses loss", 32'(seen), 32'h1);
      check("R6 sticky set", 32'(sticky_los[0]), 32'h1);
      step(300);
      check("R4 recovered", 32'(live_los[0]), 32'h0);
      check("R6 sticky holds", 32'(sticky_los[0]), 32'h1);
      pulse_clr(4'b0001);
      step(2);
      check("R6 sticky cleared", 32'(sticky_los[0]), 32'h0);

      // R3 threshold 3: two misses tolerated, three declare loss
      fail_thresh[3:0] = 4'd3;
      step(100);
      skip_n[0] = 2;
      watch0(150, seen);
      check("R3 thr3 two misses", 32'(seen), 32'h0);
      step(100);
      skip_n[0] = 3;
      watch0(200, seen);
      check("R3 thr3 three misses", 32'(seen), 32'h1);
      fail_thresh[3:0] = 4'd2;
      step(300);
      pulse_clr(4'b0001);
      step(2);

      // R7 clear in the cycle the sticky bit is being set
      stop_c[0] = 1'b1;
      for (int i = 0; i < 300 && !live_los[0]; i++) step(1);
      pulse_clr(4'b0001);
      step(2);
      check("R7 clear during loss", 32'(sticky_los[0]), 32'h1);
      stop_c[0] = 1'b0;
      step(300);
      check("R4 restart recovered", 32'(live_los[0]), 32'h0);
      pulse_clr(4'b0001);
      step(2);
      check("R6 cleared after loss", 32'(sticky_los[0]), 32'h0);

      // R5 channel independence
      stop_c[2] = 1'b1;
      step(200);
      check("R5 only ch2", 32'(live_los), 32'h4);
      stop_c[2] = 1'b0;
      step(300);

      // R8 disabled channel with dead clock
      ch_en[3] = 1'b0;
      stop_c[3] = 1'b1;
      step(200);
      check("R8 disabled dead clock", 32'(live_los[3]), 32'h0);
      stop_c[3] = 1'b0;
      ch_en[3] = 1'b1;
      step(300);
      check("R8 re-enabled clean", 32'(live_los[3]), 32'h0);

      // R9 reference loss and output policy
      stop_c[4] = 1'b1;
      step(200);
      check("R9 ref_los", 32'(ref_los), 32'h1);
      check("R9 outputs gated", 32'(out_enable), 32'h0);
      keep_outputs = 1'b1;
      step(1);
      check("R9 keep outputs", 32'(out_enable), 32'h1);
      keep_outputs = 1'b0;
      stop_c[4] = 1'b0;
      step(300);
      check("R9 ref recovered", 32'(ref_los), 32'h0);
      check("R9 outputs back", 32'(out_enable), 32'h1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule